// File: doc/BRIEF.md
# JTAG host shift engine

This block is a JTAG master for a chain with a single target TAP. It produces TCK by dividing the system clock, drives TMS and TDI, keeps the TAP reset pin inactive, and samples TDO. Software or a higher layer hands it one command at a time over a valid/ready channel. It can reset the TAP, shift an instruction-register value, shift a data-register value, or measure the instruction-register length. Each command yields one 64-bit response word over a second valid/ready channel.

Shift lengths are chosen per command, from 1 to 64 bits. Bits leave and arrive least significant first. TDO is read on each rising TCK edge while the TAP sits in a Shift state, so bit 0 is taken before it is shifted out. The final data bit is sent on the same TCK cycle that raises TMS to leave the Shift state. Between commands the TAP rests in Run-Test/Idle, and TCK is parked low.

The length probe floods the instruction path with ones and then feeds zeros. It counts clocks until the first zero returns on TDO. It then walks the TAP through Test-Logic-Reset back to Run-Test/Idle.

Top module: `jtag_shift_host`

## Requirements
- R1: `jtrst_n` is driven high at all times, including while `rst_n` is low.
- R2: After reset `cmd_ready` is 1, `rsp_valid` is 0 and `jtck` is 0. `cmd_op` selects the command: 2'b00 = TAP reset, 2'b01 = instruction shift, 2'b10 = data shift, 2'b11 = length probe. `cmd_len` holds the shift length minus one, so 0..63 selects 1..64 bits. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1.
- R3: Each TCK phase lasts `HALF_DIV` system cycles. `jtms` and `jtdi` change only while `jtck` is low, and they do not change while it is high. TCK does not restart while a response is waiting.
- R4: A reset command drives TMS high for five TCK cycles and then low for one. This leaves the TAP in Run-Test/Idle from any state. Its response word is 0.
- R5: In a shift command, bit i of `cmd_data` is presented on `jtdi` during the i-th shift clock (i = 0 first).
- R6: In a shift command, bit i of the response is the TDO value sampled on the rising edge of the i-th shift clock. Bit 0 is therefore the value present before any shift. Response bits at positions n and above are 0.
- R7: A shift of n bits gives exactly n clocks in the Shift state. The n-th clock has TMS high. Update follows, and then Run-Test/Idle.
- R8: The probe shifts `FILL_ONES` ones and then zeros into the instruction path. The response is the number of zero clocks before TDO first reads 0, which is the instruction length for lengths up to `FILL_ONES`. The probe then passes Test-Logic-Reset and ends in Run-Test/Idle.
- R9: If TDO reads 1 on all 64 zero clocks of the probe, the response is 0.
- R10: `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is 1. `cmd_ready` is 0 from acceptance until the response is taken.
- R11: Every command starts with TMS high. An instruction shift goes Select-DR, Select-IR, Capture-IR. A data shift goes Select-DR, Capture-DR. A data shift leaves the instruction register unchanged, and an instruction shift leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and TCK low |
| cmd_op | input | 2 | Command selector |
| cmd_len | input | 6 | Shift length minus one |
| cmd_data | input | 64 | Bits to send, LSB first |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 64 | Captured bits, right-aligned, or probe length |
| jtck | output | 1 | Test clock |
| jtms | output | 1 | Test mode select |
| jtdi | output | 1 | Test data to target |
| jtdo | input | 1 | Test data from target |
| jtrst_n | output | 1 | Test reset, held inactive |

## Verification
The response becomes valid on the same system edge as the final rising TCK edge. The falling TCK edge and its TMS/TDI update fall into the response-wait window, so completion and clock parking overlap. The bench stretches that window with a random 0 to 3 cycle stall on `rsp_ready`. Sometimes it offers the next command at once. It judges the overlap in three ways: the response word stays frozen, `cmd_ready` stays low until TCK is parked, and a TAP model on the pins finishes in Run-Test/Idle with the expected register contents.

// File: rtl/jt_pkg.sv
package jt_pkg;
    localparam int unsigned JT_MAX_LEN = 64;
    localparam int unsigned JT_LEN_W   = $clog2(JT_MAX_LEN);
    localparam int unsigned JT_PAT_W   = 6;
    localparam int unsigned JT_WCNT_W  = 3;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_IR    = 2'b01,
        OP_DR    = 2'b10,
        OP_PROBE = 2'b11
    } jt_op_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_WALK, PH_SHIFT, PH_FILL, PH_SEEK, PH_RESP
    } jt_phase_e;

    // TMS walks, consumed LSB first
    localparam logic [JT_PAT_W-1:0]  PAT_TLR  = 6'b011111;
    localparam logic [JT_WCNT_W-1:0] CNT_TLR  = 3'd6;
    localparam logic [JT_PAT_W-1:0]  PAT_IRH  = 6'b000011;
    localparam logic [JT_WCNT_W-1:0] CNT_IRH  = 3'd4;
    localparam logic [JT_PAT_W-1:0]  PAT_DRH  = 6'b000001;
    localparam logic [JT_WCNT_W-1:0] CNT_DRH  = 3'd3;
    localparam logic [JT_PAT_W-1:0]  PAT_EXIT = 6'b000001;
    localparam logic [JT_WCNT_W-1:0] CNT_EXIT = 3'd2;

    typedef struct packed {
        jt_phase_e              ph;
        jt_phase_e              after;
        logic [JT_PAT_W-1:0]    pat;
        logic [JT_WCNT_W-1:0]   wcnt;
        logic [JT_LEN_W-1:0]    idx;
        logic [JT_LEN_W-1:0]    last;
        logic [JT_MAX_LEN-1:0]  sh;
        logic [JT_MAX_LEN-1:0]  cap;
        logic                   tms;
        logic                   tdi;
    } jt_state_s;
endpackage

// File: rtl/jt_tck_gen.sv
module jt_tck_gen #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise,
    output logic fall
);
    localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tck;
    } gen_s;

    gen_s g_d, g_q;
    logic wrap;

    assign wrap = run && (g_q.cnt == CNT_TOP);

    always_comb begin
        g_d = g_q;
        if (!run) begin
            g_d.cnt = '0;
        end else if (wrap) begin
            g_d.cnt = '0;
            g_d.tck = !g_q.tck;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign tck  = g_q.tck;
    assign rise = wrap && !g_q.tck;
    assign fall = wrap && g_q.tck;
endmodule

// File: rtl/jt_sequencer.sv
module jt_sequencer
    import jt_pkg::*;
#(
    parameter int unsigned FILL_ONES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tck,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  tdo,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [1:0]            cmd_op,
    input  logic [JT_LEN_W-1:0]   cmd_len,
    input  logic [JT_MAX_LEN-1:0] cmd_data,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [JT_MAX_LEN-1:0] rsp_data,
    output logic                  run,
    output logic                  tms,
    output logic                  tdi
);
    localparam logic [JT_LEN_W-1:0] FILL_TOP = JT_LEN_W'(FILL_ONES - 1);
    localparam logic [JT_LEN_W-1:0] SEEK_TOP = JT_LEN_W'(JT_MAX_LEN - 1);

    jt_state_s s_d, s_q;
    logic      accept;

    // TMS/TDI to present for the coming TCK cycle
    function automatic logic [1:0] pin_bits(jt_state_s s);
        case (s.ph)
            PH_WALK:  pin_bits = {s.pat[0], 1'b0};
            PH_SHIFT: pin_bits = {(s.idx == s.last), s.sh[0]};
            PH_FILL:  pin_bits = 2'b01;
            default:  pin_bits = 2'b00;
        endcase
    endfunction

    assign cmd_ready = (s_q.ph == PH_IDLE) && !tck;
    assign accept    = cmd_valid && cmd_ready;
    assign run       = ((s_q.ph != PH_IDLE) && (s_q.ph != PH_RESP)) || tck;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    s_d.cap  = '0;
                    s_d.sh   = cmd_data;
                    s_d.last = cmd_len;
                    s_d.idx  = '0;
                    s_d.ph   = PH_WALK;
                    unique case (jt_op_e'(cmd_op))
                        OP_RESET: begin
                            s_d.pat = PAT_TLR;  s_d.wcnt = CNT_TLR;  s_d.after = PH_RESP;
                        end
                        OP_IR: begin
                            s_d.pat = PAT_IRH;  s_d.wcnt = CNT_IRH;  s_d.after = PH_SHIFT;
                        end
                        OP_DR: begin
                            s_d.pat = PAT_DRH;  s_d.wcnt = CNT_DRH;  s_d.after = PH_SHIFT;
                        end
                        default: begin
                            s_d.pat = PAT_IRH;  s_d.wcnt = CNT_IRH;  s_d.after = PH_FILL;
                        end
                    endcase
                end
            end
            PH_WALK: begin
                if (rise) begin
                    if (s_q.wcnt == JT_WCNT_W'(1)) begin
                        s_d.ph = s_q.after;
                    end else begin
                        s_d.wcnt = s_q.wcnt - 1'b1;
                        s_d.pat  = s_q.pat >> 1;
                    end
                end
            end
            PH_SHIFT: begin
                if (rise) begin
                    s_d.cap[s_q.idx] = tdo;
                    s_d.sh = s_q.sh >> 1;
                    if (s_q.idx == s_q.last) begin
                        s_d.ph = PH_WALK;  s_d.pat = PAT_EXIT;
                        s_d.wcnt = CNT_EXIT;  s_d.after = PH_RESP;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            PH_FILL: begin
                if (rise) begin
                    if (s_q.idx == FILL_TOP) begin
                        s_d.idx = '0;
                        s_d.ph  = PH_SEEK;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            PH_SEEK: begin
                if (rise) begin
                    if (!tdo || (s_q.idx == SEEK_TOP)) begin
                        s_d.cap  = tdo ? '0 : JT_MAX_LEN'(s_q.idx);
                        s_d.ph   = PH_WALK;  s_d.pat = PAT_TLR;
                        s_d.wcnt = CNT_TLR;  s_d.after = PH_RESP;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            PH_RESP: begin
                if (rsp_ready) s_d.ph = PH_IDLE;
            end
            default: s_d.ph = PH_IDLE;
        endcase
        if (accept || fall) begin
            {s_d.tms, s_d.tdi} = pin_bits(s_d);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = (s_q.ph == PH_RESP);
    assign rsp_data  = s_q.cap;
    assign tms       = s_q.tms;
    assign tdi       = s_q.tdi;
endmodule

// File: rtl/jtag_shift_host.sv
module jtag_shift_host
    import jt_pkg::*;
#(
    parameter int unsigned HALF_DIV  = 4,
    parameter int unsigned FILL_ONES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [1:0]            cmd_op,
    input  logic [JT_LEN_W-1:0]   cmd_len,
    input  logic [JT_MAX_LEN-1:0] cmd_data,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [JT_MAX_LEN-1:0] rsp_data,
    output logic                  jtck,
    output logic                  jtms,
    output logic                  jtdi,
    input  logic                  jtdo,
    output logic                  jtrst_n
);
    logic run, rise, fall;

    jt_tck_gen #(.HALF_DIV(HALF_DIV)) u_gen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tck  (jtck),
        .rise (rise),
        .fall (fall)
    );

    jt_sequencer #(.FILL_ONES(FILL_ONES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tck      (jtck),
        .rise     (rise),
        .fall     (fall),
        .tdo      (jtdo),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_op   (cmd_op),
        .cmd_len  (cmd_len),
        .cmd_data (cmd_data),
        .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready),
        .rsp_data (rsp_data),
        .run      (run),
        .tms      (jtms),
        .tdi      (jtdi)
    );

    assign jtrst_n = 1'b1;
endmodule

// File: rtl/jtag_shift_host_chk.sv
module jtag_shift_host_chk
    import jt_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic                  cmd_ready,
    input logic                  rsp_valid,
    input logic                  rsp_ready,
    input logic [JT_MAX_LEN-1:0] rsp_data,
    input logic                  jtck,
    input logic                  jtms,
    input logic                  jtdi
);
    // R3
    pins_steady_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jtck |-> ($stable(jtms) && $stable(jtdi)));

    // R3
    tck_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !jtck) |=> !jtck);

    // R10
    rsp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R10
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && rsp_valid));

    // R11
    start_tms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> jtms);
endmodule

bind jtag_shift_host jtag_shift_host_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data),
    .jtck     (jtck),
    .jtms     (jtms),
    .jtdi     (jtdi)
);

// File: tb/tb_jtag_shift_host.sv
`timescale 1ns/1ps
module tb_jtag_shift_host;
    localparam int HALF = 2;
    localparam logic [63:0] IR_RST = 64'h3;

    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SDR, T_CDR, T_SHDR, T_E1DR, T_PDR, T_E2DR, T_UDR,
        T_SIR, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR
    } tap_e;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_ready, rsp_valid, rsp_ready = 0;
    logic [1:0] cmd_op = 0;
    logic [5:0] cmd_len = 0;
    logic [63:0] cmd_data = 0, rsp_data;
    logic jtck, jtms, jtdi, jtdo, jtrst_n;

    int n_chk = 0, n_bad = 0;
    int hold_err = 0, per_err = 0, trst_err = 0, hi_len = 0;
    logic prev_tms = 0, prev_tdi = 0, prev_tck = 0;

    // target TAP model
    tap_e st = T_TLR;
    logic [63:0] ir = IR_RST, isr = 0, dhold = 64'h0123_4567_89ab_cdef, dsr = 0;
    int irl = 5, shift_cnt = 0;
    logic tdo_r = 0, stuck = 0, scramble = 0;

    always #5 clk = ~clk;

    jtag_shift_host #(.HALF_DIV(HALF), .FILL_ONES(32)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .jtck(jtck), .jtms(jtms), .jtdi(jtdi), .jtdo(jtdo), .jtrst_n(jtrst_n)
    );

    assign jtdo = tdo_r | stuck;

    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            T_TLR:  return m ? T_TLR  : T_RTI;
            T_RTI:  return m ? T_SDR  : T_RTI;
            T_SDR:  return m ? T_SIR  : T_CDR;
            T_CDR:  return m ? T_E1DR : T_SHDR;
            T_SHDR: return m ? T_E1DR : T_SHDR;
            T_E1DR: return m ? T_UDR  : T_PDR;
            T_PDR:  return m ? T_E2DR : T_PDR;
            T_E2DR: return m ? T_UDR  : T_SHDR;
            T_UDR:  return m ? T_SDR  : T_RTI;
            T_SIR:  return m ? T_TLR  : T_CIR;
            T_CIR:  return m ? T_E1IR : T_SHIR;
            T_SHIR: return m ? T_E1IR : T_SHIR;
            T_E1IR: return m ? T_UIR  : T_PIR;
            T_PIR:  return m ? T_E2IR : T_PIR;
            T_E2IR: return m ? T_UIR  : T_SHIR;
            default: return m ? T_SDR : T_RTI;
        endcase
    endfunction

    always @(posedge jtck or posedge scramble) begin
        if (scramble) begin
            st = T_SHDR;
            ir = 64'h15;
        end else begin
            case (st)
                T_TLR:  ir = IR_RST;
                T_CDR:  dsr = dhold;
                T_SHDR: begin dsr = {jtdi, dsr[63:1]}; shift_cnt++; end
                T_UDR:  dhold = dsr;
                T_CIR:  isr = 64'h1;
                T_SHIR: begin isr = (isr >> 1) | (64'(jtdi) << (irl - 1)); shift_cnt++; end
                T_UIR:  ir = isr;
                default: ;
            endcase
            st = tap_next(st, jtms);
        end
    end

    always @(negedge jtck) begin
        tdo_r = (st == T_SHDR) ? dsr[0] : (st == T_SHIR) ? isr[0] : 1'b0;
    end

    // pin monitors for R1 and R3
    always @(posedge clk) begin
        if (jtrst_n !== 1'b1) trst_err++;
        if (rst_n) begin
            if (jtck && prev_tck && (jtms != prev_tms || jtdi != prev_tdi)) hold_err++;
            if (jtck) hi_len++;
            if (!jtck && prev_tck) begin
                if (hi_len != HALF) per_err++;
                hi_len = 0;
            end
        end
        prev_tck = jtck; prev_tms = jtms; prev_tdi = jtdi;
    end

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] lmask(int n);
        return (n >= 64) ? '1 : ((64'h1 << n) - 64'h1);
    endfunction

    function automatic logic ir_seq(int j, int l, logic [63:0] d);
        return (j < l) ? (j == 0) : d[j - l];
    endfunction

    function automatic logic [63:0] ir_rsp(int n, int l, logic [63:0] d);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = ir_seq(i, l, d);
        return r;
    endfunction

    function automatic logic [63:0] ir_after(int n, int l, logic [63:0] d);
        logic [63:0] r = '0;
        for (int k = 0; k < l; k++) r[k] = ir_seq(n + k, l, d);
        return r;
    endfunction

    function automatic logic [63:0] dr_after(int n, logic [63:0] h, logic [63:0] d);
        if (n >= 64) return d;
        return (h >> n) | ((d & lmask(n)) << (64 - n));
    endfunction

    task automatic run_cmd(input logic [1:0] op, input int n, input logic [63:0] d,
                           output logic [63:0] r);
        logic [63:0] first;
        bit ok;
        int w;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_len = 6'(n - 1); cmd_data = d; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        while (!rsp_valid) @(negedge clk);
        first = rsp_data; ok = 1; w = $urandom_range(3, 0);
        repeat (w) begin
            @(negedge clk);
            if (!rsp_valid || rsp_data != first || cmd_ready) ok = 0;
        end
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        check(ok, "R10 response held", rsp_data, first);
        r = first;
    endtask

    task automatic do_dr(int n, logic [63:0] d);
        logic [63:0] r, h0, i0;
        int c0;
        h0 = dhold; i0 = ir; c0 = shift_cnt;
        run_cmd(2'b10, n, d, r);
        check(r == (h0 & lmask(n)), "R6 dr capture", r, h0 & lmask(n));
        check(dhold == dr_after(n, h0, d), "R5 dr update", dhold, dr_after(n, h0, d));
        check(shift_cnt - c0 == n, "R7 dr shift count", 64'(shift_cnt - c0), 64'(n));
        check(st == T_RTI && ir == i0, "R11 dr path", ir, i0);
    endtask

    task automatic do_ir(int n, logic [63:0] d);
        logic [63:0] r, h0;
        int c0;
        h0 = dhold; c0 = shift_cnt;
        run_cmd(2'b01, n, d, r);
        check(r == ir_rsp(n, irl, d), "R6 ir capture", r, ir_rsp(n, irl, d));
        check(ir == ir_after(n, irl, d), "R5 ir update", ir, ir_after(n, irl, d));
        check(shift_cnt - c0 == n, "R7 ir shift count", 64'(shift_cnt - c0), 64'(n));
        check(st == T_RTI && dhold == h0, "R11 ir path", dhold, h0);
    endtask

    task automatic do_probe(int l);
        logic [63:0] r;
        irl = l;
        run_cmd(2'b11, 1, 64'h0, r);
        check(r == 64'(l), "R8 probe length", r, 64'(l));
        check(st == T_RTI && ir == IR_RST, "R8 probe ends via reset", ir, IR_RST);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] r;
        int unsigned seed_v;
        seed_v = $urandom(32'h1234_abcd);
        repeat (4) @(negedge clk);
        check(jtrst_n == 1'b1, "R1 trst during reset", 64'(jtrst_n), 64'd1);
        rst_n = 1;
        @(negedge clk);
        check(cmd_ready == 1 && rsp_valid == 0 && jtck == 0, "R2 reset state",
              {61'd0, cmd_ready, rsp_valid, jtck}, 64'd4);

        // R4: reset from a scrambled TAP
        scramble = 1; #1 scramble = 0;
        run_cmd(2'b00, 1, 64'hffff, r);
        check(r == 64'd0, "R4 reset response", r, 64'd0);
        check(st == T_RTI && ir == IR_RST, "R4 tap in idle after reset", ir, IR_RST);

        // directed boundaries
        do_dr(1, 64'h1);
        do_dr(64, 64'hfeed_face_0bad_f00d);
        do_ir(1, 64'h0);
        do_ir(irl, 64'h1a);
        do_ir(64, 64'h8000_0000_0000_0001);

        // constrained random mix
        for (int i = 0; i < 24; i++) begin
            int n;
            logic [63:0] d;
            n = $urandom_range(64, 1);
            d = {$urandom, $urandom};
            if ($urandom_range(1, 0) == 1) do_dr(n, d);
            else do_ir(n, d);
        end

        // R8 probe lengths, including the fill boundary
        do_probe(3);
        do_probe(8);
        do_probe(32);
        irl = 5;
        do_ir(7, 64'h55);

        // R9 TDO stuck high
        stuck = 1;
        run_cmd(2'b11, 1, 64'h0, r);
        stuck = 0;
        check(r == 64'd0, "R9 probe without zero", r, 64'd0);
        check(st == T_RTI, "R9 ends in idle", 64'(st), 64'(T_RTI));

        repeat (10) @(negedge clk);
        check(hold_err == 0, "R3 pins steady while tck high", 64'(hold_err), 64'd0);
        check(per_err == 0, "R3 tck high phase length", 64'(per_err), 64'd0);
        check(trst_err == 0, "R1 trst held high", 64'(trst_err), 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule